// File: doc/BRIEF.md
# Tile-Map VGA Renderer

This block drives a 640x480, 60 Hz VGA display from a 25.175 MHz pixel clock. It keeps a horizontal and a vertical beam counter, derives active-low sync pulses from them and produces one bit each of red, green and blue. The brick field is a bit-per-tile map kept outside the block. The block presents a tile address formed from the upper bits of the beam counters and reads back one bit in the same clock. A tile is 32 pixels wide and 16 lines tall.

Two rectangles are overlaid on the brick field: a paddle and a square ball, each placed by its top-left coordinate inputs. While it scans, the block notes whether any visible pixel fell on a set tile. At the close of every frame it raises a level-cleared flag when none did. The game logic can use that flag to start a new level, so no separate brick count is needed.

All timing figures, coordinate widths, tile sizes and object sizes are parameters. The bench uses a shrunken raster so that it can sweep whole frames.

Top module: `tile_vga_renderer`

## Requirements
- R1: A line lasts H_VIS+H_FP+H_SYNC+H_BP clocks (default 640+16+96+48 = 800). `hsync_n` is low exactly for column counts H_VIS+H_FP up to H_VIS+H_FP+H_SYNC-1 and high for all others.
- R2: A frame lasts V_VIS+V_FP+V_SYNC+V_BP lines (default 480+10+2+33 = 525). `vsync_n` is low for the whole of lines V_VIS+V_FP up to V_VIS+V_FP+V_SYNC-1 and high for all others.
- R3: `map_col` equals the column count shifted right by TILE_W_LOG2 (default 5). `map_row` equals the line count shifted right by TILE_H_LOG2 (default 4). Both follow the current counts combinationally, and `map_bit` is sampled in that same clock.
- R4: For a count outside the visible area (column >= H_VIS or line >= V_VIS), red, green and blue are all 0.
- R5: For a visible count not covered by the paddle or the ball, the colour {red,green,blue} is 3'b100 when `map_bit` is 1 and 3'b000 when it is 0.
- R6: For a visible count inside the paddle, the colour is 3'b011, and it overrides a brick. The paddle spans columns paddle_x to paddle_x+PAD_W-1 and lines paddle_y to paddle_y+PAD_H-1.
- R7: For a visible count inside the ball, the colour is 3'b111, and it overrides both paddle and brick. The ball spans columns ball_x to ball_x+BALL_SZ-1 and lines ball_y to ball_y+BALL_SZ-1.
- R8: `level_clear` changes only on the last clock of a frame. It then becomes 1 if no visible count in that frame saw `map_bit` = 1, counting set tiles hidden by the paddle or ball as seen, and 0 otherwise. It holds that value through the next frame. Set tiles outside the visible area do not count.
- R9: Sync and colour outputs are registered. The values for the counts (h,v) appear after the clock edge at which the counters hold (h,v).
- R10: An asynchronous active-low `rst_n` sets both counters to 0, both syncs high, all colours to 0 and `level_clear` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| paddle_x | input | H_BITS | Paddle left column |
| paddle_y | input | V_BITS | Paddle top line |
| ball_x | input | H_BITS | Ball left column |
| ball_y | input | V_BITS | Ball top line |
| map_col | output | H_BITS-TILE_W_LOG2 | Tile column address |
| map_row | output | V_BITS-TILE_H_LOG2 | Tile row address |
| map_bit | input | 1 | Tile bit read at map_row/map_col |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| red | output | 1 | Red pixel bit |
| green | output | 1 | Green pixel bit |
| blue | output | 1 | Blue pixel bit |
| level_clear | output | 1 | No brick was drawn in the last frame |

## Verification
Some properties are checked on every cycle by the assertions: the counters wrap at their totals, the line count moves only at the end of a line, no colour appears outside the visible area, and `level_clear` moves only at a frame boundary. Only the bench scenarios can show that each pixel takes the right colour under the paddle-over-brick and ball-over-paddle priorities, that clipped objects at the raster edges stay hidden in the blanking, and that the flag is set for an empty map or for bricks placed only in invisible tiles. Those scenarios also show that a single brick in the last visible tile keeps the flag low.

// File: rtl/tile_vga_renderer.sv
module tile_vga_renderer #(
  parameter int H_VIS       = 640,
  parameter int H_FP        = 16,
  parameter int H_SYNC      = 96,
  parameter int H_BP        = 48,
  parameter int V_VIS       = 480,
  parameter int V_FP        = 10,
  parameter int V_SYNC      = 2,
  parameter int V_BP        = 33,
  parameter int H_BITS      = 10,
  parameter int V_BITS      = 10,
  parameter int TILE_W_LOG2 = 5,
  parameter int TILE_H_LOG2 = 4,
  parameter int PAD_W       = 64,
  parameter int PAD_H       = 8,
  parameter int BALL_SZ     = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [H_BITS-1:0]             paddle_x,
  input  logic [V_BITS-1:0]             paddle_y,
  input  logic [H_BITS-1:0]             ball_x,
  input  logic [V_BITS-1:0]             ball_y,
  output logic [H_BITS-TILE_W_LOG2-1:0] map_col,
  output logic [V_BITS-TILE_H_LOG2-1:0] map_row,
  input  logic                          map_bit,
  output logic                          hsync_n,
  output logic                          vsync_n,
  output logic                          red,
  output logic                          green,
  output logic                          blue,
  output logic                          level_clear
);
  localparam int H_TOT  = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int V_TOT  = V_VIS + V_FP + V_SYNC + V_BP;
  localparam int HS_BEG = H_VIS + H_FP;
  localparam int HS_END = HS_BEG + H_SYNC;
  localparam int VS_BEG = V_VIS + V_FP;
  localparam int VS_END = VS_BEG + V_SYNC;

  logic [H_BITS-1:0] hcnt;
  logic [V_BITS-1:0] vcnt;
  logic [2:0]        rgb_q;
  logic              seen;

  wire line_end  = (hcnt == H_BITS'(H_TOT - 1));
  wire frame_end = line_end && (vcnt == V_BITS'(V_TOT - 1));
  wire visible   = (hcnt < H_BITS'(H_VIS)) && (vcnt < V_BITS'(V_VIS));
  wire brick     = visible && map_bit;

  wire [H_BITS:0] hx = {1'b0, hcnt};
  wire [V_BITS:0] vx = {1'b0, vcnt};

  wire in_pad = (hx >= {1'b0, paddle_x}) && (hx < {1'b0, paddle_x} + (H_BITS+1)'(PAD_W)) &&
                (vx >= {1'b0, paddle_y}) && (vx < {1'b0, paddle_y} + (V_BITS+1)'(PAD_H));
  wire in_ball = (hx >= {1'b0, ball_x}) && (hx < {1'b0, ball_x} + (H_BITS+1)'(BALL_SZ)) &&
                 (vx >= {1'b0, ball_y}) && (vx < {1'b0, ball_y} + (V_BITS+1)'(BALL_SZ));

  assign map_col = hcnt[H_BITS-1:TILE_W_LOG2];
  assign map_row = vcnt[V_BITS-1:TILE_H_LOG2];

  logic [2:0] pix;
  always_comb begin
    if (!visible)     pix = 3'b000;
    else if (in_ball) pix = 3'b111;
    else if (in_pad)  pix = 3'b011;
    else if (brick)   pix = 3'b100;
    else              pix = 3'b000;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (line_end) begin
      hcnt <= '0;
      vcnt <= frame_end ? '0 : vcnt + 1'b1;
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hsync_n     <= 1'b1;
      vsync_n     <= 1'b1;
      rgb_q       <= 3'b000;
      seen        <= 1'b0;
      level_clear <= 1'b0;
    end else begin
      hsync_n <= !((hcnt >= H_BITS'(HS_BEG)) && (hcnt < H_BITS'(HS_END)));
      vsync_n <= !((vcnt >= V_BITS'(VS_BEG)) && (vcnt < V_BITS'(VS_END)));
      rgb_q   <= pix;
      if (frame_end) begin
        level_clear <= !(seen || brick);
        seen        <= 1'b0;
      end else if (brick) begin
        seen <= 1'b1;
      end
    end
  end

  assign {red, green, blue} = rgb_q;

  assert_hcnt_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (hcnt == H_BITS'(H_TOT - 1)) |=> (hcnt == '0));

  assert_vcnt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hcnt != H_BITS'(H_TOT - 1)) |=> $stable(vcnt));

  assert_vcnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vcnt < V_BITS'(V_TOT));

  assert_blank_dark_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (red || green || blue) |-> ($past(hcnt) < H_BITS'(H_VIS)) && ($past(vcnt) < V_BITS'(V_VIS)));

  assert_flag_frame_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(level_clear));
endmodule

// File: tb/tile_vga_renderer_test.sv
`timescale 1ns/1ps
module tile_vga_renderer_test;
  localparam int HV = 24, HF = 2, HS = 3, HB = 3;
  localparam int VV = 12, VF = 1, VS = 2, VB = 2;
  localparam int HT = HV + HF + HS + HB;
  localparam int VT = VV + VF + VS + VB;
  localparam int HBITS = 5, VBITS = 5, TWL = 3, THL = 2;
  localparam int PW = 6, PH = 2, BS = 3;

  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  int px, py, bx, by;
  logic bmap [0:7][0:3];
  logic [HBITS-TWL-1:0] map_col;
  logic [VBITS-THL-1:0] map_row;
  logic map_bit, hsync_n, vsync_n, red, green, blue, level_clear;

  assign map_bit = bmap[map_row][map_col];

  tile_vga_renderer #(
    .H_VIS(HV), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
    .V_VIS(VV), .V_FP(VF), .V_SYNC(VS), .V_BP(VB),
    .H_BITS(HBITS), .V_BITS(VBITS), .TILE_W_LOG2(TWL), .TILE_H_LOG2(THL),
    .PAD_W(PW), .PAD_H(PH), .BALL_SZ(BS)
  ) uut (
    .clk(clk), .rst_n(rst_n),
    .paddle_x(HBITS'(px)), .paddle_y(VBITS'(py)),
    .ball_x(HBITS'(bx)), .ball_y(VBITS'(by)),
    .map_col(map_col), .map_row(map_row), .map_bit(map_bit),
    .hsync_n(hsync_n), .vsync_n(vsync_n),
    .red(red), .green(green), .blue(blue), .level_clear(level_clear)
  );

  int checks = 0, fails = 0;
  int h, v, e_cls, mseen;
  logic e_hs, e_vs, e_lc;
  logic [2:0] e_rgb;

  // Reference model built from the requirements (R1, R2, R4-R9)
  always @(posedge clk or negedge rst_n) begin : model
    int vis, br, inb, inp;
    if (!rst_n) begin
      h <= 0; v <= 0; e_hs <= 1; e_vs <= 1; e_rgb <= 0; e_cls <= 0; e_lc <= 0; mseen <= 0;
    end else begin
      vis = (h < HV && v < VV) ? 1 : 0;
      br  = (vis != 0 && bmap[v / 4][h / 8]) ? 1 : 0;
      inb = (h >= bx && h < bx + BS && v >= by && v < by + BS) ? 1 : 0;
      inp = (h >= px && h < px + PW && v >= py && v < py + PH) ? 1 : 0;
      if (vis == 0)      begin e_rgb <= 3'b000; e_cls <= 0; end
      else if (inb != 0) begin e_rgb <= 3'b111; e_cls <= 4; end
      else if (inp != 0) begin e_rgb <= 3'b011; e_cls <= 3; end
      else if (br != 0)  begin e_rgb <= 3'b100; e_cls <= 2; end
      else               begin e_rgb <= 3'b000; e_cls <= 1; end
      e_hs <= !(h >= HV + HF && h < HV + HF + HS);
      e_vs <= !(v >= VV + VF && v < VV + VF + VS);
      if (h == HT - 1 && v == VT - 1) begin
        e_lc <= !(mseen != 0 || br != 0);
        mseen <= 0;
      end else if (br != 0) mseen <= 1;
      if (h == HT - 1) begin h <= 0; v <= (v == VT - 1) ? 0 : v + 1; end
      else h <= h + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at h=%0d v=%0d: got %0d expected %0d", req, h, v, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      check("R10 reset outputs", {hsync_n, vsync_n, red, green, blue, level_clear}, 6'b110000);
      check("R10 reset address", {map_row, map_col}, 0);
    end else begin
      check("R3 map_col", map_col, h / 8);
      check("R3 map_row", map_row, v / 4);
      check("R1 hsync R9", hsync_n, e_hs);
      check("R2 vsync R9", vsync_n, e_vs);
      case (e_cls)
        0: check("R4 blanking", {red, green, blue}, e_rgb);
        4: check("R7 ball R9", {red, green, blue}, e_rgb);
        3: check("R6 paddle R9", {red, green, blue}, e_rgb);
        default: check("R5 brick/background R9", {red, green, blue}, e_rgb);
      endcase
      check("R8 level_clear", level_clear, e_lc);
    end
  end

  task automatic next_frame();
    @(negedge clk);
    while (!(h == 0 && v == 0)) @(negedge clk);
  endtask

  task automatic fill(input int mode, input int k);
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 4; c++)
        case (mode)
          0: bmap[r][c] = 1'b0;
          1: bmap[r][c] = 1'b1;
          2: bmap[r][c] = ((r + c) % 2) == 0;
          3: bmap[r][c] = (c == 3) || (r >= 3);
          4: bmap[r][c] = (r == 2 && c == 2);
          default: bmap[r][c] = ((r * 4 + c + k) % 5) == 0;
        endcase
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    fill(0, 0);
    px = 0; py = 0; bx = 0; by = 0;
    repeat (3) @(negedge clk);
    // R10 checked during reset; start first frame with a full map (R5, R8 flag stays 0)
    fill(1, 0); bx = 5; by = 3; px = 10; py = 9;
    rst_n = 1;
    next_frame();
    // R7 ball over bricks on a checkerboard
    fill(2, 0); bx = 7; by = 2; px = 2; py = 10;
    next_frame();
    // R8 empty map -> flag set at frame end
    fill(0, 0);
    next_frame();
    // R8 bricks only in invisible tiles -> flag still set
    fill(3, 0); bx = 12; by = 5;
    next_frame();
    // R8 single brick in last visible tile -> flag clear; R6 paddle over it
    fill(4, 0); px = 18; py = 10; bx = 0; by = 0;
    next_frame();
    // R4 R6 R7 objects clipped at the right and bottom edges
    fill(2, 0); bx = 22; by = 10; px = 20; py = 11;
    next_frame();
    // Sweep of ball/paddle placements and map patterns
    for (int k = 0; k < 12; k++) begin
      fill(5, k);
      bx = (k * 3) % 32; by = (k * 5) % 16;
      px = (k * 7) % 30; py = (k * 2) % 14;
      next_frame();
    end
    fill(0, 0);
    next_frame();
    next_frame();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule